// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a transfer interrupted midway has left hung, for example when a slave is stuck in the middle of a byte and holds SDA low. A start pulse asks the block to look at the bus. If the controller reports the bus idle and SDA reads high, nothing needs doing, and the block reports completion on the next cycle. Otherwise it takes the SCL and SDA pins away from the normal controller. It drives SCL open-drain and clocks the slave until the slave lets go of SDA, or until the pulse budget runs out.

Each phase of the sequence lasts one delay period, counted in system clock cycles and captured when the sequence starts. The sequence holds SCL low for one period. Then, while SDA is still low and the budget allows, it gives full clock pulses, each released for one period and then pulled low for one period. It checks SDA at the close of every low phase. At the end it releases SCL for one final period, returns the pins to the controller and pulses its done output. A fail flag reports a slave that still held SDA low after the last pulse. Issuing a STOP afterwards is left to the controller.

Top module: `i2c_unstick`

## Requirements
- R1: After reset, scl_pull_o, pin_ovr_o, done_o and fail_o are all 0.
- R2: A start seen while idle with busy_i = 0 and synchronized SDA high gives done_o = 1 in the very next cycle, with pin_ovr_o and scl_pull_o staying 0 and fail_o = 0.
- R3: A start seen while idle with busy_i = 1 or SDA low sets pin_ovr_o = 1 from the next cycle. It stays 1 without a break until the cycle before done_o.
- R4: Recovery begins with SCL pulled (scl_pull_o = 1) for exactly D cycles, where D is the captured delay.
- R5: Each clock pulse is D cycles with scl_pull_o = 0 followed by D cycles with scl_pull_o = 1. SDA passes through a 2-flop synchronizer and is examined only at the last cycle of each pulled phase.
- R6: If SDA reads high at the end of a pulled phase, pulsing stops. The number of pulses equals the number of SCL releases the slave needed before freeing SDA.
- R7: At most MAX_PULSES (default 10) pulses are given. If SDA is still low at the end of the pulled phase after the last pulse, fail_o = 1 alongside done_o.
- R8: If SDA reads high at the same decision point where the pulse budget is used up, the release wins and fail_o stays 0.
- R9: After pulsing ends, SCL is released (scl_pull_o = 0) for D cycles. In the next cycle, pin_ovr_o = 0 and done_o = 1 together. done_o lasts exactly one cycle, and fail_o holds its value until the next accepted start.
- R10: delay_i is captured when a start is accepted, and later changes do not affect the running sequence. A value of 0 acts as 1.
- R11: A start asserted while a sequence runs is ignored.
- R12: scl_pull_o is 1 only while pin_ovr_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a bus check and recovery |
| sda_i | input | 1 | Raw SDA level from the pad |
| busy_i | input | 1 | Bus-busy flag from the I2C controller |
| delay_i | input | DLY_W | Phase length in clock cycles |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| pin_ovr_o | output | 1 | 1 selects this block as owner of the bus pins |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | SDA still low after the last allowed pulse |

## Verification
Two events can coincide at one decision point: the slave freeing SDA, and the pulse budget running out, both at the end of the pulled phase after the last pulse. A bench slave model that frees SDA after exactly the budgeted number of SCL releases provokes this case. The result is judged by fail_o at done, which must be 0, and by the counted pulse total and phase lengths. The neighbouring cases are one release fewer and a slave that never frees SDA, and these pin down the boundary from both sides.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PULL = 2'd1,
    ST_REL  = 2'd2,
    ST_TAIL = 2'd3
  } unstick_state_t;
endpackage

// File: rtl/i2c_unstick_sync.sv
module i2c_unstick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/i2c_unstick_timer.sv
module i2c_unstick_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
  import i2c_unstick_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int MAX_PULSES  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             sda_i,
  input  logic             busy_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             scl_pull_o,
  output logic             pin_ovr_o,
  output logic             done_o,
  output logic             fail_o
);
  localparam int PC_W = $clog2(MAX_PULSES + 1);
  localparam logic [PC_W-1:0] PC_MAX = PC_W'(MAX_PULSES);

  unstick_state_t   state_q;
  logic [DLY_W-1:0] dly_q;
  logic [PC_W-1:0]  pulses_q;
  logic             give_up_q;
  logic             sda_s;
  logic             tmr_exp;
  logic             tmr_load;
  logic [DLY_W-1:0] tmr_len;
  logic             need_rec;

  i2c_unstick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (sda_i),
    .q_o (sda_s)
  );

  assign need_rec = busy_i | ~sda_s;

  always_comb begin
    tmr_load = 1'b0;
    tmr_len  = dly_q;
    unique case (state_q)
      ST_IDLE: begin
        tmr_load = start_i & need_rec;
        tmr_len  = delay_i;
      end
      ST_PULL, ST_REL: tmr_load = tmr_exp;
      default:         tmr_load = 1'b0;
    endcase
  end

  i2c_unstick_timer #(.W(DLY_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load_i   (tmr_load),
    .len_i    (tmr_len),
    .expire_o (tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      dly_q      <= '0;
      pulses_q   <= '0;
      give_up_q  <= 1'b0;
      scl_pull_o <= 1'b0;
      pin_ovr_o  <= 1'b0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            dly_q     <= delay_i;
            pulses_q  <= '0;
            give_up_q <= 1'b0;
            fail_o    <= 1'b0;
            if (need_rec) begin
              state_q    <= ST_PULL;
              pin_ovr_o  <= 1'b1;
              scl_pull_o <= 1'b1;
            end else begin
              done_o <= 1'b1;
            end
          end
        end
        ST_PULL: begin
          if (tmr_exp) begin
            scl_pull_o <= 1'b0;
            if (sda_s || pulses_q == PC_MAX) begin
              state_q   <= ST_TAIL;
              give_up_q <= ~sda_s;
            end else begin
              state_q  <= ST_REL;
              pulses_q <= pulses_q + 1'b1;
            end
          end
        end
        ST_REL: begin
          if (tmr_exp) begin
            scl_pull_o <= 1'b1;
            state_q    <= ST_PULL;
          end
        end
        ST_TAIL: begin
          if (tmr_exp) begin
            pin_ovr_o <= 1'b0;
            done_o    <= 1'b1;
            fail_o    <= give_up_q;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
  parameter int MAX_PULSES = 10
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic scl_pull_o,
  input logic pin_ovr_o,
  input logic done_o,
  input logic fail_o
);
  localparam int RC_W = $clog2(MAX_PULSES + 2) + 1;
  logic            pull_d;
  logic [RC_W-1:0] rel_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_d  <= 1'b0;
      rel_cnt <= '0;
    end else begin
      pull_d <= scl_pull_o;
      if (!pin_ovr_o)                 rel_cnt <= '0;
      else if (pull_d && !scl_pull_o) rel_cnt <= rel_cnt + 1'b1;
    end
  end

  // R12
  pull_needs_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    scl_pull_o |-> pin_ovr_o);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9
  done_pins_back_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !pin_ovr_o && ($past(pin_ovr_o) || $past(start_i)));

  // R3
  ovr_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_ovr_o) |-> $past(start_i) && scl_pull_o);

  // R7
  fail_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_o) |-> done_o);

  // R7
  pulse_budget_chk: assert property (@(posedge clk) disable iff (rst)
    pin_ovr_o |-> (int'(rel_cnt) <= MAX_PULSES + 1));
endmodule

bind i2c_unstick i2c_unstick_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .scl_pull_o (scl_pull_o),
  .pin_ovr_o  (pin_ovr_o),
  .done_o     (done_o),
  .fail_o     (fail_o)
);

// File: tb/i2c_unstick_tb.sv
module i2c_unstick_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W      = 16;
  localparam int MAXP       = 10;
  localparam int NEVER      = 99;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic busy_i = 1'b0;
  logic [DLY_W-1:0] delay_i = '0;
  logic scl_pull_o, pin_ovr_o, done_o, fail_o;
  logic sda_line;

  int n_rel = 0;
  int tests = 0;
  int fails = 0;
  bit clr = 1'b0;
  bit finished = 1'b0;

  int rises, ovr_cyc, low_cyc, high_cyc, first_low, done_cnt, cyc;
  bit pull_prev, fail_at_done, ovr_at_done, last_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = (n_rel == 0) ? 1'b1 : (rises >= n_rel);

  i2c_unstick #(.DLY_W(DLY_W), .MAX_PULSES(MAXP)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .sda_i(sda_line),
    .busy_i(busy_i), .delay_i(delay_i), .scl_pull_o(scl_pull_o),
    .pin_ovr_o(pin_ovr_o), .done_o(done_o), .fail_o(fail_o));

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (clr) begin
      rises = 0; ovr_cyc = 0; low_cyc = 0; high_cyc = 0; first_low = 0;
      done_cnt = 0; pull_prev = 1'b0; fail_at_done = 1'b0;
      ovr_at_done = 1'b0; last_pull = 1'b0;
    end else begin
      if (pin_ovr_o) begin
        ovr_cyc = ovr_cyc + 1;
        last_pull = scl_pull_o;
        if (scl_pull_o) begin
          low_cyc = low_cyc + 1;
          if (rises == 0) first_low = first_low + 1;
        end else high_cyc = high_cyc + 1;
      end
      if (pull_prev && !scl_pull_o) rises = rises + 1;
      pull_prev = scl_pull_o;
      if (done_o) begin
        done_cnt = done_cnt + 1;
        fail_at_done = fail_o;
        ovr_at_done = pin_ovr_o;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pulses(input int n);
    return (n > MAXP) ? MAXP : n;
  endfunction

  task automatic run_case(input bit busy, input int n, input int d, input bit poke);
    int de, p, w;
    bit rec;
    de  = (d == 0) ? 1 : d;
    rec = busy || (n != 0);
    p   = rec ? exp_pulses(n) : 0;
    n_rel = n;
    busy_i = busy;
    delay_i = DLY_W'(d);
    @(posedge clk); #1 clr = 1'b1;
    repeat (4) @(posedge clk);
    #1 clr = 1'b0; start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    if (poke) begin
      repeat (4) @(posedge clk);
      #1 start_i = 1'b1; delay_i = DLY_W'(d + 5);
      @(posedge clk); #1 start_i = 1'b0;
    end
    w = 0;
    while (done_cnt == 0 && w < 3000) begin
      @(posedge clk); w++;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
    chk(ovr_at_done == 0, "R9 pins returned at done", ovr_at_done, 0);
    chk(fail_at_done == (n > MAXP), "R7/R8 fail flag", fail_at_done, (n > MAXP));
    chk(fail_o == (n > MAXP), "R9 fail held", fail_o, (n > MAXP));
    if (!rec) begin
      chk(ovr_cyc == 0, "R2 no override", ovr_cyc, 0);
      chk(rises == 0, "R2 no SCL activity", rises, 0);
    end else begin
      chk(ovr_cyc == de * (2 + 2 * p), "R3/R10/R11 override length", ovr_cyc, de * (2 + 2 * p));
      chk(first_low == de, "R4 initial pull length", first_low, de);
      chk(rises == p + 1, "R6/R7 pulse count", rises - 1, p);
      chk(low_cyc == de * (p + 1), "R5 pulled cycles", low_cyc, de * (p + 1));
      chk(high_cyc == de * (p + 1), "R5/R9 released cycles", high_cyc, de * (p + 1));
      chk(last_pull == 0, "R9 SCL released at end", last_pull, 0);
    end
  endtask

  initial begin
    cyc = 0; clr = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(scl_pull_o == 0 && pin_ovr_o == 0 && done_o == 0 && fail_o == 0,
        "R1 reset outputs", {scl_pull_o, pin_ovr_o, done_o, fail_o}, 0);
    rst = 1'b0;
    void'($urandom(32'd4242));
    run_case(0, 0, 4, 0);          // R2 idle bus
    run_case(1, 0, 4, 0);          // R3 busy only, SDA high: zero pulses
    run_case(0, 1, 3, 0);          // R6 one pulse
    run_case(0, MAXP - 1, 3, 0);   // R6 one below budget
    run_case(0, MAXP, 4, 0);       // R8 release on the last decision
    run_case(0, NEVER, 3, 0);      // R7 give up
    run_case(1, NEVER, 0, 0);      // R10 zero delay acts as one
    run_case(1, 0, 1, 0);          // R10 unit delay
    run_case(0, 5, 6, 1);          // R11 start and delay change ignored
    for (int k = 0; k < 40; k++) begin
      int n, d;
      n = int'($urandom_range(0, 12));
      if (n > MAXP) n = NEVER;
      d = int'($urandom_range(3, 8));
      run_case(1'($urandom_range(0, 1)), n, d, (n != 0) && ($urandom_range(0, 3) == 0));
    end
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule